// File: doc/BRIEF.md
# Dual-Register Product-Term Macrocell Array

This block models the output stage of a small programmable logic device. It holds a row of macrocells. Each one receives two groups of product terms from an AND array that lies outside the block. Each group is reduced to a sum term. Each macrocell has two flip-flops. No global clock drives them: each flip-flop loads on the rising edge of its own clock product term and is cleared by its own reset product term. A fast system clock samples every clock product term and compares it with the value from the previous cycle to find the edges.

Three configuration bits per macrocell control it. One ORs the second sum term into the first path. One chooses whether the pin takes the combinational sum or the first register. One inverts the pin data. Every pin has three features:
- an output enable driven by its own product term;
- a dedicated input path back to the array;
- two register feedbacks, so buried registers stay visible while the pin acts as an input.

A preset line is shared by every register and is synchronous to each register's own clock. A security bit, while verify mode is active, forces every output enable off.

Top module: `plm_array`

## Requirements
- R1: Each sum term is the OR of its 8 product-term inputs. Cell c uses bits [8c+7:8c] of `sum_a_pt` and `sum_b_pt`. With `cfg_combine[c]`=0, the primary path of cell c is the A sum alone.
- R2: With `cfg_combine[c]`=1, the primary path of cell c is the A sum ORed with the B sum. The primary path feeds both register A and the combinational pin data.
- R3: Register B always loads the B sum alone, whatever the combine bit.
- R4: A register loads only in a system-clock cycle where its clock product term is 1 and was 0 in the previous cycle. Otherwise it holds. The new value shows on `fb_a`/`fb_b` after that system clock edge.
- R5: A register whose reset product term is 1 at a system clock edge is cleared at that edge. The reset wins over a clock edge and over preset.
- R6: When `sync_preset` is 1 at a register's clock edge, the register loads 1 instead of its sum. Preset has no effect in a cycle without an edge.
- R7: `pin_out[c]` = `cfg_invert[c]` XOR (`cfg_regout[c]` ? register A : primary path).
- R8: `pin_oe[c]` equals `oe_pt[c]`. When `secure` and `verify` are both 1, every `pin_oe` bit is 0 in that same cycle.
- R9: `pin_fb` equals `pin_in` at all times, regardless of output enable. `fb_a`/`fb_b` always present the register contents.
- R10: While `rst` is 1, every register is cleared at each system clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sum_a_pt | input | 80 | Product terms of the A sum, 8 per cell |
| sum_b_pt | input | 80 | Product terms of the B sum, 8 per cell |
| clk_a_pt | input | 10 | Clock product term of register A per cell |
| clk_b_pt | input | 10 | Clock product term of register B per cell |
| rst_a_pt | input | 10 | Reset product term of register A per cell |
| rst_b_pt | input | 10 | Reset product term of register B per cell |
| oe_pt | input | 10 | Output enable product term per cell |
| cfg_combine | input | 10 | Merge B sum into the primary path |
| cfg_regout | input | 10 | Pin data from register A instead of the sum |
| cfg_invert | input | 10 | Invert pin data |
| sync_preset | input | 1 | Shared preset, sampled at register clock edges |
| secure | input | 1 | Security bit |
| verify | input | 1 | Verify mode |
| pin_in | input | 10 | Pin input level per cell |
| pin_out | output | 10 | Pin output data per cell |
| pin_oe | output | 10 | Pin output enable per cell |
| pin_fb | output | 10 | Pin input feedback to the array |
| fb_a | output | 10 | Register A feedback |
| fb_b | output | 10 | Register B feedback |

## Verification
The bench aims at the cycle where the clock product term rises while reset and preset are also high. A design with the wrong priority sets the register instead of clearing it. It also checks that a clock held high does not reload the register. A level-triggered design would then follow its sum every cycle. Other directed cases check that register B ignores the combine bit, which a shared merge path would break, and that the security bit blanks the enables only while verify is active. Random sparse product terms then compare every output against a reference model in each cycle.

// File: rtl/plm_pkg.sv
package plm_pkg;

    localparam int unsigned CELLS_DEF = 10;
    localparam int unsigned PTS_DEF   = 8;
    localparam int unsigned REGS_PER_CELL = 2;

    typedef struct packed {
        logic combine;
        logic reg_out;
        logic invert;
    } cell_cfg_t;

    typedef struct packed {
        logic ck;
        logic clr;
        logic d;
    } reg_ctl_t;

    function automatic logic pin_value(input cell_cfg_t cfg, input logic q, input logic comb);
        return cfg.invert ^ (cfg.reg_out ? q : comb);
    endfunction

    function automatic logic next_q(input reg_ctl_t ctl, input logic ck_prev,
                                    input logic preset, input logic q);
        if (ctl.clr)
            return 1'b0;
        else if (ctl.ck && !ck_prev)
            return preset ? 1'b1 : ctl.d;
        else
            return q;
    endfunction

endpackage

// File: rtl/plm_sum_term.sv
module plm_sum_term
    import plm_pkg::*;
#(
    parameter int unsigned PTS = PTS_DEF
) (
    input  logic [PTS-1:0] pt_a,
    input  logic [PTS-1:0] pt_b,
    input  logic           combine,
    output logic           path_a,
    output logic           path_b
);
    logic sum_a;
    logic sum_b;

    always_comb begin
        sum_a  = |pt_a;
        sum_b  = |pt_b;
        path_b = sum_b;
        path_a = combine ? (sum_a | sum_b) : sum_a;
    end

endmodule

// File: rtl/plm_pt_reg.sv
module plm_pt_reg
    import plm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_ctl_t ctl,
    input  logic     preset,
    output logic     q
);
    logic ck_prev;

    always_ff @(posedge clk) begin
        ck_prev <= ctl.ck;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= next_q(ctl, ck_prev, preset, q);
    end

endmodule

// File: rtl/plm_macrocell.sv
module plm_macrocell
    import plm_pkg::*;
#(
    parameter int unsigned PTS = PTS_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [PTS-1:0] pt_a,
    input  logic [PTS-1:0] pt_b,
    input  logic           ck_a,
    input  logic           ck_b,
    input  logic           clr_a,
    input  logic           clr_b,
    input  logic           oe_term,
    input  cell_cfg_t      cfg,
    input  logic           preset,
    input  logic           hiz,
    input  logic           pad_in,
    output logic           pad_out,
    output logic           pad_oe,
    output logic           pad_fb,
    output logic           q_a,
    output logic           q_b
);
    logic path_a;
    logic path_b;
    reg_ctl_t ctl [REGS_PER_CELL];
    logic     q   [REGS_PER_CELL];

    plm_sum_term #(.PTS(PTS)) u_sum (
        .pt_a    (pt_a),
        .pt_b    (pt_b),
        .combine (cfg.combine),
        .path_a  (path_a),
        .path_b  (path_b)
    );

    always_comb begin
        ctl[0] = '{ck: ck_a, clr: clr_a, d: path_a};
        ctl[1] = '{ck: ck_b, clr: clr_b, d: path_b};
    end

    for (genvar r = 0; r < REGS_PER_CELL; r++) begin : g_reg
        plm_pt_reg u_reg (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl[r]),
            .preset (preset),
            .q      (q[r])
        );
    end

    always_comb begin
        q_a     = q[0];
        q_b     = q[1];
        pad_out = pin_value(cfg, q[0], path_a);
        pad_oe  = oe_term & ~hiz;
        pad_fb  = pad_in;
    end

endmodule

// File: rtl/plm_array.sv
module plm_array
    import plm_pkg::*;
#(
    parameter int unsigned CELLS = CELLS_DEF,
    parameter int unsigned PTS   = PTS_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CELLS*PTS-1:0] sum_a_pt,
    input  logic [CELLS*PTS-1:0] sum_b_pt,
    input  logic [CELLS-1:0]     clk_a_pt,
    input  logic [CELLS-1:0]     clk_b_pt,
    input  logic [CELLS-1:0]     rst_a_pt,
    input  logic [CELLS-1:0]     rst_b_pt,
    input  logic [CELLS-1:0]     oe_pt,
    input  logic [CELLS-1:0]     cfg_combine,
    input  logic [CELLS-1:0]     cfg_regout,
    input  logic [CELLS-1:0]     cfg_invert,
    input  logic                 sync_preset,
    input  logic                 secure,
    input  logic                 verify,
    input  logic [CELLS-1:0]     pin_in,
    output logic [CELLS-1:0]     pin_out,
    output logic [CELLS-1:0]     pin_oe,
    output logic [CELLS-1:0]     pin_fb,
    output logic [CELLS-1:0]     fb_a,
    output logic [CELLS-1:0]     fb_b
);
    logic hiz;

    assign hiz = secure & verify;

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        cell_cfg_t cfg;
        assign cfg = '{combine: cfg_combine[c], reg_out: cfg_regout[c], invert: cfg_invert[c]};

        plm_macrocell #(.PTS(PTS)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .pt_a    (sum_a_pt[c*PTS +: PTS]),
            .pt_b    (sum_b_pt[c*PTS +: PTS]),
            .ck_a    (clk_a_pt[c]),
            .ck_b    (clk_b_pt[c]),
            .clr_a   (rst_a_pt[c]),
            .clr_b   (rst_b_pt[c]),
            .oe_term (oe_pt[c]),
            .cfg     (cfg),
            .preset  (sync_preset),
            .hiz     (hiz),
            .pad_in  (pin_in[c]),
            .pad_out (pin_out[c]),
            .pad_oe  (pin_oe[c]),
            .pad_fb  (pin_fb[c]),
            .q_a     (fb_a[c]),
            .q_b     (fb_b[c])
        );
    end

endmodule

// File: rtl/plm_array_chk.sv
module plm_array_chk #(
    parameter int unsigned CELLS = 10
) (
    input logic             clk,
    input logic             rst,
    input logic [CELLS-1:0] clk_a_pt,
    input logic [CELLS-1:0] rst_a_pt,
    input logic [CELLS-1:0] rst_b_pt,
    input logic [CELLS-1:0] oe_pt,
    input logic             sync_preset,
    input logic             secure,
    input logic             verify,
    input logic [CELLS-1:0] pin_oe,
    input logic [CELLS-1:0] fb_a,
    input logic [CELLS-1:0] fb_b
);
    logic [CELLS-1:0] ck_seen;
    logic [CELLS-1:0] edge_a;

    always_ff @(posedge clk) ck_seen <= clk_a_pt;
    assign edge_a = clk_a_pt & ~ck_seen;

    // R5: a reset product term clears its register at that edge
    p_clear_a_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fb_a & $past(rst_a_pt)) == '0));
    p_clear_b_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fb_b & $past(rst_b_pt)) == '0));

    // R4: without an edge or reset, register A holds
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((fb_a ^ $past(fb_a)) & ~$past(edge_a | rst_a_pt)) == '0));

    // R6: preset at an edge sets the register
    p_preset_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~fb_a & $past(edge_a & ~rst_a_pt & {CELLS{sync_preset}})) == '0));

    // R8: secure verify blanks every enable; otherwise enable follows its term
    p_hiz_r8: assert property (@(posedge clk) disable iff (rst)
        (secure && verify) |-> (pin_oe == '0));
    p_oe_r8: assert property (@(posedge clk) disable iff (rst)
        !(secure && verify) |-> (pin_oe == oe_pt));

    // R10: reset clears both register banks
    p_reset_r10: assert property (@(posedge clk)
        rst |=> (fb_a == '0 && fb_b == '0));

endmodule

bind plm_array plm_array_chk #(.CELLS(CELLS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clk_a_pt    (clk_a_pt),
    .rst_a_pt    (rst_a_pt),
    .rst_b_pt    (rst_b_pt),
    .oe_pt       (oe_pt),
    .sync_preset (sync_preset),
    .secure      (secure),
    .verify      (verify),
    .pin_oe      (pin_oe),
    .fb_a        (fb_a),
    .fb_b        (fb_b)
);

// File: tb/plm_array_tb.sv
module plm_array_tb;
    localparam int N = 10;
    localparam int P = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N*P-1:0] sum_a_pt = '0, sum_b_pt = '0;
    logic [N-1:0] clk_a_pt = '0, clk_b_pt = '0, rst_a_pt = '0, rst_b_pt = '0;
    logic [N-1:0] oe_pt = '0, cfg_combine = '0, cfg_regout = '0, cfg_invert = '0, pin_in = '0;
    logic sync_preset = 1'b0, secure = 1'b0, verify = 1'b0;
    logic [N-1:0] pin_out, pin_oe, pin_fb, fb_a, fb_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [N-1:0] m_a = '0, m_b = '0, m_pa = '0, m_pb = '0;

    always #2 clk = ~clk;

    plm_array u_dut (
        .clk(clk), .rst(rst), .sum_a_pt(sum_a_pt), .sum_b_pt(sum_b_pt),
        .clk_a_pt(clk_a_pt), .clk_b_pt(clk_b_pt), .rst_a_pt(rst_a_pt), .rst_b_pt(rst_b_pt),
        .oe_pt(oe_pt), .cfg_combine(cfg_combine), .cfg_regout(cfg_regout),
        .cfg_invert(cfg_invert), .sync_preset(sync_preset), .secure(secure),
        .verify(verify), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_fb(pin_fb), .fb_a(fb_a), .fb_b(fb_b)
    );

    function automatic logic path_a(int c);
        logic sa = |sum_a_pt[c*P +: P];
        logic sb = |sum_b_pt[c*P +: P];
        return cfg_combine[c] ? (sa | sb) : sa;
    endfunction

    function automatic logic path_b(int c);
        return |sum_b_pt[c*P +: P];
    endfunction

    function automatic logic reg_next(logic q, logic clr, logic ck, logic pv, logic d);
        if (rst || clr) return 1'b0;
        if (ck && !pv) return sync_preset ? 1'b1 : d;
        return q;
    endfunction

    function automatic logic [N-1:0] exp_pin_out();
        logic [N-1:0] v;
        for (int c = 0; c < N; c++)
            v[c] = cfg_invert[c] ^ (cfg_regout[c] ? m_a[c] : path_a(c));
        return v;
    endfunction

    function automatic logic [N-1:0] exp_pin_oe();
        return (secure && verify) ? '0 : oe_pt;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input bit compare);
        logic [N-1:0] na, nb;
        for (int c = 0; c < N; c++) begin
            na[c] = reg_next(m_a[c], rst_a_pt[c], clk_a_pt[c], m_pa[c], path_a(c));
            nb[c] = reg_next(m_b[c], rst_b_pt[c], clk_b_pt[c], m_pb[c], path_b(c));
        end
        @(posedge clk);
        m_a = na; m_b = nb; m_pa = clk_a_pt; m_pb = clk_b_pt;
        @(negedge clk);
        if (compare) begin
            check(fb_a === m_a, "R4 fb_a", fb_a, m_a);
            check(fb_b === m_b, "R4 fb_b", fb_b, m_b);
            check(pin_out === exp_pin_out(), "R7 pin_out", pin_out, exp_pin_out());
            check(pin_oe === exp_pin_oe(), "R8 pin_oe", pin_oe, exp_pin_oe());
            check(pin_fb === pin_in, "R9 pin_fb", pin_fb, pin_in);
        end
    endtask

    function automatic logic [N*P-1:0] sparse();
        logic [N*P-1:0] v;
        for (int i = 0; i < N*P; i++) v[i] = ($urandom_range(15) == 0);
        return v;
    endfunction

    function automatic logic [N-1:0] biased(int k);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = ($urandom_range(k-1) == 0);
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        oe_pt = '1;
        repeat (4) step(1'b0);
        rst = 1'b0;
        // R10: registers clear after reset
        check(fb_a === '0 && fb_b === '0, "R10 reset", fb_a | fb_b, '0);

        // R1: cell 0 path from A sum alone
        sum_a_pt[3] = 1'b1;
        step(1'b1);
        check(pin_out[0] === 1'b1, "R1 sumA to pin", pin_out, 10'b1);
        sum_a_pt = '0; sum_b_pt[P+0] = 1'b0; sum_b_pt[5] = 1'b1;
        step(1'b1);
        check(pin_out[0] === 1'b0, "R1 sumB excluded", pin_out, '0);
        // R2: combine merges B into primary path
        cfg_combine[0] = 1'b1;
        step(1'b1);
        check(pin_out[0] === 1'b1, "R2 combine", pin_out, 10'b1);
        // R2: register A loads combined path on edge
        clk_a_pt[0] = 1'b1;
        step(1'b1);
        check(fb_a[0] === 1'b1, "R2 reg A combined", fb_a, 10'b1);
        // R3: register B ignores combine (A nonzero, B zero)
        sum_a_pt = '0; sum_b_pt = '0; sum_a_pt[1*P+2] = 1'b1; cfg_combine[1] = 1'b1;
        clk_b_pt[1] = 1'b1;
        step(1'b1);
        check(fb_b[1] === 1'b0, "R3 reg B own sum", fb_b, '0);
        // R6: preset with edge on cell 2 (sum zero)
        clk_a_pt[2] = 1'b0; step(1'b1);
        sync_preset = 1'b1; clk_a_pt[2] = 1'b1;
        step(1'b1);
        check(fb_a[2] === 1'b1, "R6 preset at edge", fb_a, 10'b100);
        // R6/R4: clock held high, no further load: clear via reset then hold preset
        rst_a_pt[3] = 1'b1; step(1'b1); rst_a_pt[3] = 1'b0;
        clk_a_pt[3] = 1'b1; step(1'b1);
        step(1'b1);
        check(fb_a[3] === 1'b1, "R6 preset edge cell3", fb_a, 10'b1000);
        rst_a_pt[3] = 1'b1; step(1'b1); rst_a_pt[3] = 1'b0;
        step(1'b1);
        check(fb_a[3] === 1'b0, "R6 no edge no preset", fb_a, '0);
        // R5: reset beats edge and preset
        clk_a_pt[4] = 1'b0; step(1'b1);
        clk_a_pt[4] = 1'b1; rst_a_pt[4] = 1'b1; sum_a_pt[4*P] = 1'b1;
        step(1'b1);
        check(fb_a[4] === 1'b0, "R5 reset priority", fb_a, '0);
        rst_a_pt[4] = 1'b0; sync_preset = 1'b0;
        // R7: invert and register select
        cfg_regout[2] = 1'b1; cfg_invert[2] = 1'b1;
        step(1'b1);
        check(pin_out[2] === 1'b0, "R7 inverted reg", pin_out, '0);
        // R8: secure+verify blanks, secure alone does not
        secure = 1'b1; verify = 1'b1;
        step(1'b1);
        check(pin_oe === '0, "R8 secure verify", pin_oe, '0);
        verify = 1'b0;
        step(1'b1);
        check(pin_oe === oe_pt, "R8 secure only", pin_oe, oe_pt);
        // R9: input path with outputs disabled
        oe_pt = '0; pin_in = 10'h2A5;
        step(1'b1);
        check(pin_fb === 10'h2A5, "R9 input path", pin_fb, 10'h2A5);

        for (int k = 0; k < 3000; k++) begin
            sum_a_pt = sparse(); sum_b_pt = sparse();
            clk_a_pt = biased(2); clk_b_pt = biased(2);
            rst_a_pt = biased(8); rst_b_pt = biased(8);
            oe_pt = biased(2); pin_in = biased(2);
            if (k % 100 == 0) begin
                cfg_combine = biased(2); cfg_regout = biased(2); cfg_invert = biased(2);
            end
            sync_preset = ($urandom_range(3) == 0);
            secure = ($urandom_range(1) == 0); verify = ($urandom_range(3) == 0);
            step(1'b1);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule